// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives an 8-bit successive-approximation converter. It makes the conversion bit period from the system clock, or takes it from a tick supplied by an outside oscillator. It runs one sampling period and then eight bit trials, from the most significant bit to the least. Each trial code goes out to the DAC, and the block reads back the verdict of an external comparator. The finished code is held in a result register that software can also write.

Software controls the sequencer through a small control-write port that carries an enable bit and a start bit. Clearing the start bit during a conversion cancels it. The stored result is not touched, and a fixed settling wait of two bit periods follows before the sampling stage may be used again. A static flag reports when the selected divider gives a bit period outside the permitted window at the configured system clock frequency.

Top module: `sar_seq`

## Requirements
- R1: `clk_sel` sets the bit period P. Code 2'b00 gives 2 clocks, 2'b01 gives 8 clocks and 2'b10 gives 32 clocks. With 2'b11, each one-cycle pulse on `rc_tick` ends a period.
- R2: A conversion takes exactly 9 bit periods. `done` is high in the cycle that follows the 9·P-th rising edge after the edge that accepted the start write.
- R3: After the first (sampling) period, `dac_code` is 0x80. At the end of each later period, the bit under trial stays 1 if `cmp_in` is 1 (input at or above `dac_code`) and is cleared otherwise, and the next lower bit is set. The final code is written to `result`.
- R4: When a conversion completes, `done` is high for one cycle only, `busy` is low in that same cycle, and `result` already holds the new code.
- R5: A control write with enable=1 and start=0 while `busy` is high aborts the conversion. On the next cycle `busy` is low and `result` is unchanged, and no `done` follows.
- R6: After an abort, `hold_wait` stays high for exactly 2·P cycles and then falls. Start writes made while `hold_wait` is high are ignored.
- R7: A start write is accepted only if `conv_on` was already high before that write. A single write that sets enable and start together turns on `conv_on` and leaves `busy` low.
- R8: A `res_we` pulse loads `res_wdata` into `result` when `busy` and `hold_wait` are both low. While a conversion runs, `res_we` is ignored.
- R9: `cfg_bad` is 1 for a divider select whose period at `CLK_KHZ` falls below `MIN_NS` or above `MAX_NS`. With the defaults (5 MHz clock, 1600 to 6400 ns) it is 1 for 2'b00 and 0 for 2'b01, 2'b10 and 2'b11.
- R10: A synchronous active-high reset clears `busy`, `hold_wait`, `done`, `conv_on`, `dac_code` and `result`, and clears the divider count.
- R11: A control write with enable=0 while `busy` is high stops the conversion at once. No wait follows, `result` is unchanged and no `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Bit-period source select |
| rc_tick | input | 1 | Period tick from outside oscillator (select 2'b11) |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_go | input | 1 | Start bit of the control write |
| res_we | input | 1 | Result register write strobe |
| res_wdata | input | NBITS | Result register write data |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| dac_code | output | NBITS | Current trial code |
| busy | output | 1 | Conversion in progress |
| hold_wait | output | 1 | Post-abort wait in progress |
| conv_on | output | 1 | Converter enabled |
| result | output | NBITS | Result register |
| done | output | 1 | One-cycle completion pulse |
| cfg_bad | output | 1 | Selected period outside permitted window |

## Verification
With P the period of the selected divider, `done` and the new `result` are due 9·P cycles after the start edge. The trial code changes at every multiple of P. An abort shows on `busy` one cycle later, and `hold_wait` holds for 2·P cycles. The bench counts rising edges from the accepting edge and samples on falling edges. A scoreboard queues each expected code together with its latency, and a monitor compares them when `done` rises, so each check lands in the cycle its result is due. Ignored stimulus (a start that arrives with the enable, a start during the wait, a result write while busy) is checked on the outputs right after it and before anything else can change them.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        CS_DIV_A = 2'b00,
        CS_DIV_B = 2'b01,
        CS_DIV_C = 2'b10,
        CS_EXT   = 2'b11
    } clk_src_e;

    // Period in ns is div * 1e6 / clk_khz; compare by cross-multiplication.
    function automatic logic period_bad(longint div, longint clk_khz,
                                        longint min_ns, longint max_ns);
        longint lhs;
        lhs = div * 64'd1000000;
        return (lhs < min_ns * clk_khz) || (lhs > max_ns * clk_khz);
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV_A   = 2,
    parameter int DIV_B   = 8,
    parameter int DIV_C   = 32,
    parameter int CLK_KHZ = 5000,
    parameter int MIN_NS  = 1600,
    parameter int MAX_NS  = 6400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    input  logic       rc_tick,
    input  logic       run,
    input  logic       restart,
    output logic       tick,
    output logic       cfg_bad
);
    import sar_pkg::*;

    localparam int DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int DIV_MAX = (DIV_AB > DIV_C) ? DIV_AB : DIV_C;
    localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic BAD_A = period_bad(DIV_A, CLK_KHZ, MIN_NS, MAX_NS);
    localparam logic BAD_B = period_bad(DIV_B, CLK_KHZ, MIN_NS, MAX_NS);
    localparam logic BAD_C = period_bad(DIV_C, CLK_KHZ, MIN_NS, MAX_NS);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;
    logic             ext;

    always_comb begin
        ext     = 1'b0;
        last    = '0;
        cfg_bad = 1'b0;
        case (clk_src_e'(sel))
            CS_DIV_A: begin last = CNT_W'(DIV_A - 1); cfg_bad = BAD_A; end
            CS_DIV_B: begin last = CNT_W'(DIV_B - 1); cfg_bad = BAD_B; end
            CS_DIV_C: begin last = CNT_W'(DIV_C - 1); cfg_bad = BAD_C; end
            default:  ext = 1'b1;
        endcase
        tick = run && (ext ? rc_tick : (cnt_q == last));
        if (restart || !run || ext) cnt_d = '0;
        else if (cnt_q == last)     cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int NBITS = 8,
    parameter int PH_W  = 4
) (
    input  logic [NBITS-1:0] code,
    input  logic [PH_W-1:0]  phase,
    input  logic             cmp,
    output logic [NBITS-1:0] nxt
);
    logic [NBITS-1:0] cur;

    always_comb begin
        cur = NBITS'(1) << (NBITS - int'(phase));
        if (phase == '0) begin
            nxt            = '0;
            nxt[NBITS-1]   = 1'b1;
        end else begin
            nxt = (cmp ? code : (code & ~cur)) | (cur >> 1);
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int NBITS      = 8,
    parameter int ABORT_WAIT = 2,
    parameter int DIV_A      = 2,
    parameter int DIV_B      = 8,
    parameter int DIV_C      = 32,
    parameter int CLK_KHZ    = 5000,
    parameter int MIN_NS     = 1600,
    parameter int MAX_NS     = 6400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic             rc_tick,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             ctl_go,
    input  logic             res_we,
    input  logic [NBITS-1:0] res_wdata,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code,
    output logic             busy,
    output logic             hold_wait,
    output logic             conv_on,
    output logic [NBITS-1:0] result,
    output logic             done,
    output logic             cfg_bad
);
    localparam int PH_W = $clog2(NBITS + 1);
    localparam int WC_W = $clog2(ABORT_WAIT + 1);

    typedef struct packed {
        logic             en;
        logic             busy;
        logic             waiting;
        logic [WC_W-1:0]  wcnt;
        logic [PH_W-1:0]  phase;
        logic [NBITS-1:0] code;
        logic [NBITS-1:0] result;
        logic             done;
    } st_t;

    st_t              st_d, st_q;
    logic             tick, restart, start_ok, abort_req;
    logic [NBITS-1:0] nxt_code;

    assign start_ok  = !st_q.busy && !st_q.waiting && ctl_we && ctl_en && ctl_go && st_q.en;
    assign abort_req = st_q.busy && ctl_we && ctl_en && !ctl_go;
    assign restart   = start_ok || abort_req;

    sar_tick_gen #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
        .CLK_KHZ(CLK_KHZ), .MIN_NS(MIN_NS), .MAX_NS(MAX_NS)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .sel     (clk_sel),
        .rc_tick (rc_tick),
        .run     (st_q.busy || st_q.waiting),
        .restart (restart),
        .tick    (tick),
        .cfg_bad (cfg_bad)
    );

    sar_trial #(.NBITS(NBITS), .PH_W(PH_W)) u_trial (
        .code  (st_q.code),
        .phase (st_q.phase),
        .cmp   (cmp_in),
        .nxt   (nxt_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (ctl_we) st_d.en = ctl_en;
        if (st_q.busy) begin
            if (ctl_we && !ctl_en) begin
                st_d.busy  = 1'b0;
                st_d.phase = '0;
            end else if (abort_req) begin
                st_d.busy    = 1'b0;
                st_d.waiting = 1'b1;
                st_d.wcnt    = '0;
                st_d.phase   = '0;
            end else if (tick) begin
                st_d.code = nxt_code;
                if (st_q.phase == PH_W'(NBITS)) begin
                    st_d.busy   = 1'b0;
                    st_d.result = nxt_code;
                    st_d.done   = 1'b1;
                    st_d.phase  = '0;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end
        end else if (st_q.waiting) begin
            if (ctl_we && !ctl_en) begin
                st_d.waiting = 1'b0;
            end else if (tick) begin
                if (st_q.wcnt == WC_W'(ABORT_WAIT - 1)) st_d.waiting = 1'b0;
                else                                   st_d.wcnt    = st_q.wcnt + 1'b1;
            end
        end else begin
            if (res_we) st_d.result = res_wdata;
            if (start_ok) begin
                st_d.busy  = 1'b1;
                st_d.phase = '0;
                st_d.code  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dac_code  = st_q.code;
    assign busy      = st_q.busy;
    assign hold_wait = st_q.waiting;
    assign conv_on   = st_q.en;
    assign result    = st_q.result;
    assign done      = st_q.done;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_we,
    input logic             ctl_en,
    input logic             ctl_go,
    input logic             res_we,
    input logic             busy,
    input logic             hold_wait,
    input logic             conv_on,
    input logic             done,
    input logic [NBITS-1:0] result
);
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_we && ctl_en && !ctl_go) |=> (!busy && hold_wait && !done && $stable(result)));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(busy && hold_wait));

    p_wait_no_start_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_wait && ctl_we && ctl_go) |=> !busy);

    p_same_write_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !hold_wait && !conv_on && ctl_we && ctl_en && ctl_go) |=> !busy);

    p_busy_write_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && res_we) |=> ($stable(result) || done));

    p_off_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_we && !ctl_en) |=> (!busy && !hold_wait && !done && $stable(result)));

endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] clk_sel = 2'b01;
    logic       rc_tick = 1'b0;
    logic       ctl_we = 1'b0, ctl_en = 1'b0, ctl_go = 1'b0;
    logic       res_we = 1'b0;
    logic [7:0] res_wdata = '0;
    logic       cmp_in;
    logic [7:0] dac_code, result;
    logic       busy, hold_wait, conv_on, done, cfg_bad;
    logic [7:0] vin = '0;

    int nchk = 0, nbad = 0, cyc = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    typedef struct { logic [7:0] val; int lat; int t0; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp_in = (vin >= dac_code);

    sar_seq u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .rc_tick(rc_tick),
        .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_go(ctl_go),
        .res_we(res_we), .res_wdata(res_wdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .busy(busy), .hold_wait(hold_wait),
        .conv_on(conv_on), .result(result), .done(done), .cfg_bad(cfg_bad)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Control write; called at a falling edge, returns at the next one.
    task automatic wr_ctl(input logic e, input logic g);
        ctl_we = 1'b1; ctl_en = e; ctl_go = g;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic conv_go(input logic [1:0] sel, input logic [7:0] v, input int lat, output int t0);
        exp_t e;
        clk_sel = sel; vin = v;
        wr_ctl(1'b1, 1'b1);
        t0 = cyc;
        e.val = v; e.lat = lat; e.t0 = t0;
        sb.push_back(e);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares each completion against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) chk(!done, "R4 done single pulse", done, 0);
            if (done) begin
                if (sb.size() == 0) chk(1'b0, "R5 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(result == e.val, "R3 result code", result, e.val);
                    chk(!busy, "R4 busy low at done", busy, 0);
                    if (e.lat >= 0) chk(cyc - e.t0 == e.lat, "R2 latency", cyc - e.t0, e.lat);
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int t0;
        int n;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !hold_wait && !done && !conv_on, "R10 flags after reset",
            {busy, hold_wait, done, conv_on}, 0);
        chk(result == 8'h00 && dac_code == 8'h00, "R10 result/dac after reset", result, 0);

        // R9 configuration flag
        clk_sel = 2'b00; #1 chk(cfg_bad == 1'b1, "R9 sel00 bad", cfg_bad, 1);
        clk_sel = 2'b01; #1 chk(cfg_bad == 1'b0, "R9 sel01 ok", cfg_bad, 0);
        clk_sel = 2'b10; #1 chk(cfg_bad == 1'b0, "R9 sel10 ok", cfg_bad, 0);
        clk_sel = 2'b11; #1 chk(cfg_bad == 1'b0, "R9 sel11 ok", cfg_bad, 0);
        clk_sel = 2'b01;
        @(negedge clk);

        // R7 enable and start in the same write
        wr_ctl(1'b1, 1'b1);
        chk(conv_on == 1'b1, "R7 enable taken", conv_on, 1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R7 start with enable ignored", busy, 0);

        // R3 trial sequence, P=8, input 0xA5
        conv_go(2'b01, 8'hA5, 72, t0);
        while (cyc != t0 + 8) @(negedge clk);
        chk(dac_code == 8'h80, "R3 first trial", dac_code, 8'h80);
        while (cyc != t0 + 16) @(negedge clk);
        chk(dac_code == 8'hC0, "R3 msb kept", dac_code, 8'hC0);
        while (cyc != t0 + 24) @(negedge clk);
        chk(dac_code == 8'hA0, "R3 bit cleared", dac_code, 8'hA0);
        wait_idle();

        // R1/R2 fast divider, several codes
        conv_go(2'b00, 8'h00, 18, t0); wait_idle();
        conv_go(2'b00, 8'hFF, 18, t0); wait_idle();
        conv_go(2'b00, 8'h5A, 18, t0); wait_idle();
        // R1 slow divider
        conv_go(2'b10, 8'h37, 288, t0); wait_idle();

        // R1 outside tick source
        conv_go(2'b11, 8'h81, -1, t0);
        for (int k = 0; k < 9; k++) begin
            repeat (2) @(negedge clk);
            rc_tick = 1'b1;
            @(negedge clk);
            rc_tick = 1'b0;
            if (k == 7) chk(busy == 1'b1, "R1 rc still busy after 8 ticks", busy, 1);
        end
        wait_idle();

        // R8 idle result write
        res_we = 1'b1; res_wdata = 8'h3C;
        @(negedge clk);
        res_we = 1'b0;
        chk(result == 8'h3C, "R8 idle write", result, 8'h3C);

        // R8 write during conversion ignored
        conv_go(2'b01, 8'h10, 72, t0);
        res_we = 1'b1; res_wdata = 8'h99;
        @(negedge clk);
        res_we = 1'b0;
        chk(result == 8'h3C, "R8 busy write ignored", result, 8'h3C);
        wait_idle();

        // R5 abort, R6 wait length and ignored start
        keep = result;
        clk_sel = 2'b01; vin = 8'hE7;
        wr_ctl(1'b1, 1'b1);
        repeat (20) @(negedge clk);
        wr_ctl(1'b1, 1'b0);
        chk(busy == 1'b0 && hold_wait == 1'b1, "R5 abort stops", {busy, hold_wait}, 1);
        chk(result == keep, "R5 result kept", result, keep);
        n = 0;
        while (hold_wait) begin
            if (n == 3) begin ctl_we = 1'b1; ctl_en = 1'b1; ctl_go = 1'b1; end
            if (n == 4) ctl_we = 1'b0;
            n++;
            @(negedge clk);
        end
        ctl_we = 1'b0;
        chk(n == 16, "R6 wait length", n, 16);
        chk(busy == 1'b0, "R6 start during wait ignored", busy, 0);
        chk(result == keep, "R5 result after wait", result, keep);

        // R11 disable during conversion
        wr_ctl(1'b1, 1'b1);
        chk(busy == 1'b1, "R11 restart after wait", busy, 1);
        repeat (10) @(negedge clk);
        wr_ctl(1'b0, 1'b0);
        chk(!busy && !hold_wait && !conv_on, "R11 stop no wait", {busy, hold_wait, conv_on}, 0);
        chk(result == keep, "R11 result kept", result, keep);
        repeat (100) @(negedge clk);

        chk(sb.size() == 0, "R2 all completions seen", sb.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule